// File: doc/BRIEF.md
# Shared Interrupt Routing Distributor

This block takes a parameterised set of shared external interrupt lines and steers each one toward the local interrupt interface of one processor, or of all processors at once. Shared interrupt identifiers start at 32, so line `l` inside the block carries identifier `32 + l`. Each line is brought into the clock domain through a two-flop synchroniser, its trigger sense is decoded from a packed 2-bit code, and the resulting request is presented on a registered per-processor, per-line request vector.

Software programs the block through a single-cycle read/write register port. The port holds a global enable, a packed trigger-mode table with sixteen 2-bit fields per word, and one target word per line. A target word names either a single processor or, with its top bit set, all processors. In that second case, the first processor that claims the line takes ownership. The block supports no other subset of processors. Per-line masking, priority and completion tracking belong to the processors' local interfaces. Those interfaces hand claims back to this block through an acknowledge strobe and an identifier for each processor.

Top module: `irq_route_dist`

## Requirements
- R1: After reset, every request output is 0, the control word reads 0, every trigger-mode word reads 0 and every target word reads 0.
- R2: Bit 0 of the control word at address 0x0 is the global enable, and the other bits of that word read 0. While the enable is 0, every request output is 0.
- R3: The trigger-mode table starts at address 0x100. Line `l` uses bits `[2*(l%16)+1 : 2*(l%16)]` of the word at `0x100 + 4*(l/16)`. Fields of absent lines, and words past the last line, read 0. Writing a word changes only the fields it contains, so a read-modify-write of one field leaves the other fields as they were.
- R4: The target word of line `l` is at `0x1000 + 4*l`. Bits `[CPU_W-1:0]` hold the processor number and bit 31 selects broadcast. All other bits read 0.
- R5: Trigger code 0 is active-high level and code 1 is active-low level. In level mode, the request follows the synchronised input level.
- R6: Trigger code 2 is rising edge and code 3 is falling edge. In edge mode, the configured edge latches a pending request that stays set after the input returns, until it is acknowledged.
- R7: When broadcast is off, a line's request appears only on the output of its target processor. An acknowledge from any other processor has no effect.
- R8: When broadcast is on, a line's request appears on the output of every processor. An acknowledge from any one processor withdraws the request from all processors.
- R9: In level mode, an acknowledge withdraws the request while the input stays active. The request returns only after the input has gone inactive and then active again.
- R10: While the enable is 0, edges are not latched, acknowledges are ignored and pending edge state is held. After the enable returns to 1, a request that was pending before it was cleared reappears.
- R11: An acknowledge names a line by its identifier, which is the line index plus 32. An identifier below 32, or one that matches no present line, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid on the following cycle |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_LINES | Asynchronous shared interrupt inputs; bit `l` carries identifier 32+l |
| ack_vld | input | NUM_CPUS | Per-processor claim strobe |
| ack_id | input | NUM_CPUS*ID_W | Per-processor claimed identifier; processor `c` uses slice `c*ID_W +: ID_W` |
| req_out | output | NUM_CPUS*NUM_LINES | Registered requests; bit `c*NUM_LINES + l` is line `l` toward processor `c` |

## Verification
The hardest state to reach from the ports is a pending edge request that survives a disable window. To get there, the bench latches a rising edge and then clears the enable. While the enable is 0, it sends a valid claim for that line and produces a fresh falling edge on another line. It then sets the enable again and checks that only the original request returns. Ownership of broadcast lines and rejection of claims from non-target processors are reached in a similar way: the bench first latches a request and then sends claims with wrong processors and wrong identifiers before sending the correct one.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    TRG_LVL_HI    = 2'd0,
    TRG_LVL_LO    = 2'd1,
    TRG_EDGE_RISE = 2'd2,
    TRG_EDGE_FALL = 2'd3
  } trig_e;

  localparam int unsigned CTRL_ADDR     = 32'h0000;
  localparam int unsigned TRIG_BASE     = 32'h0100;
  localparam int unsigned TGT_BASE      = 32'h1000;
  localparam int unsigned SHARED_ID_LO  = 32;
  localparam int unsigned FIELDS_PER_WD = 16;
  localparam int unsigned BCAST_BIT     = 31;

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 20,
  parameter int NUM_CPUS  = 4,
  parameter int ADDR_W    = 16,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int TRIG_WDS = (NUM_LINES + FIELDS_PER_WD - 1) / FIELDS_PER_WD
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic                      glob_en,
  output logic [2*NUM_LINES-1:0]    trig_mode,
  output logic [NUM_LINES*CPU_W-1:0] tgt_cpu,
  output logic [NUM_LINES-1:0]      tgt_bcast
);

  logic [31:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en   <= 1'b0;
      trig_mode <= '0;
      tgt_cpu   <= '0;
      tgt_bcast <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(CTRL_ADDR))
        glob_en <= wdata[0];
      for (int l = 0; l < NUM_LINES; l++) begin
        if (addr == ADDR_W'(TRIG_BASE + 4 * (l / FIELDS_PER_WD)))
          trig_mode[2*l +: 2] <= wdata[2*(l % FIELDS_PER_WD) +: 2];
        if (addr == ADDR_W'(TGT_BASE + 4 * l)) begin
          tgt_cpu[l*CPU_W +: CPU_W] <= wdata[CPU_W-1:0];
          tgt_bcast[l]              <= wdata[BCAST_BIT];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(CTRL_ADDR))
      rd_mux[0] = glob_en;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (addr == ADDR_W'(TRIG_BASE + 4 * (l / FIELDS_PER_WD)))
        rd_mux[2*(l % FIELDS_PER_WD) +: 2] = trig_mode[2*l +: 2];
      if (addr == ADDR_W'(TGT_BASE + 4 * l)) begin
        rd_mux[CPU_W-1:0] = tgt_cpu[l*CPU_W +: CPU_W];
        rd_mux[BCAST_BIT] = tgt_bcast[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= rd_mux;
  end

endmodule

// File: rtl/irq_line_unit.sv
module irq_line_unit
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_async,
  input  logic [1:0] mode,
  input  logic       en,
  input  logic       ack_hit,
  output logic       active,
  output logic       pend
);

  logic sync_a, sync_b, prev_b;
  logic insvc;
  logic is_edge, edge_seen, lvl_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      sync_a <= irq_async;
      sync_b <= sync_a;
      prev_b <= sync_b;
    end
  end

  always_comb begin
    is_edge   = mode[1];
    lvl_on    = (trig_e'(mode) == TRG_LVL_LO) ? ~sync_b : sync_b;
    edge_seen = (trig_e'(mode) == TRG_EDGE_RISE) ? (sync_b & ~prev_b)
                                                 : (~sync_b & prev_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      insvc <= 1'b0;
    end else if (en) begin
      if (is_edge && edge_seen)
        pend <= 1'b1;
      else if (ack_hit)
        pend <= 1'b0;
      if (is_edge || !lvl_on)
        insvc <= 1'b0;
      else if (ack_hit)
        insvc <= 1'b1;
    end
  end

  assign active = is_edge ? pend : (lvl_on & ~insvc);

endmodule

// File: rtl/irq_deliver.sv
module irq_deliver #(
  parameter int NUM_LINES = 20,
  parameter int NUM_CPUS  = 4,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [NUM_LINES-1:0]         active,
  input  logic [NUM_LINES*CPU_W-1:0]   tgt_cpu,
  input  logic [NUM_LINES-1:0]         tgt_bcast,
  output logic [NUM_CPUS*NUM_LINES-1:0] req
);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic sel;
      assign sel = tgt_bcast[l] || (tgt_cpu[l*CPU_W +: CPU_W] == CPU_W'(c));
      always_ff @(posedge clk) begin
        if (rst)
          req[c*NUM_LINES + l] <= 1'b0;
        else
          req[c*NUM_LINES + l] <= en & active[l] & sel;
      end
    end
  end

endmodule

// File: rtl/irq_route_dist.sv
module irq_route_dist
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 20,
  parameter int NUM_CPUS  = 4,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 8,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic [NUM_LINES-1:0]          irq_in,
  input  logic [NUM_CPUS-1:0]           ack_vld,
  input  logic [NUM_CPUS*ID_W-1:0]      ack_id,
  output logic [NUM_CPUS*NUM_LINES-1:0] req_out
);

  logic                       glob_en;
  logic [2*NUM_LINES-1:0]     trig_mode;
  logic [NUM_LINES*CPU_W-1:0] tgt_cpu;
  logic [NUM_LINES-1:0]       tgt_bcast;
  logic [NUM_LINES-1:0]       ack_hit;
  logic [NUM_LINES-1:0]       active;
  logic [NUM_LINES-1:0]       pend_w;

  irq_route_regs #(
    .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .glob_en(glob_en),
    .trig_mode(trig_mode), .tgt_cpu(tgt_cpu), .tgt_bcast(tgt_bcast)
  );

  // A claim hits a line when its identifier matches and the claiming
  // processor is the target, or the line is broadcast.
  always_comb begin
    ack_hit = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (ack_vld[c] &&
            ack_id[c*ID_W +: ID_W] == ID_W'(SHARED_ID_LO + l) &&
            (tgt_bcast[l] || tgt_cpu[l*CPU_W +: CPU_W] == CPU_W'(c)))
          ack_hit[l] = 1'b1;
      end
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    irq_line_unit line_i (
      .clk(clk), .rst(rst), .irq_async(irq_in[l]),
      .mode(trig_mode[2*l +: 2]), .en(glob_en), .ack_hit(ack_hit[l]),
      .active(active[l]), .pend(pend_w[l])
    );
  end

  irq_deliver #(
    .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)
  ) deliver_i (
    .clk(clk), .rst(rst), .en(glob_en), .active(active),
    .tgt_cpu(tgt_cpu), .tgt_bcast(tgt_bcast), .req(req_out)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_LINES = 20,
  parameter int NUM_CPUS  = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          glob_en,
  input logic [NUM_LINES-1:0]          pend,
  input logic [NUM_CPUS*NUM_LINES-1:0] req_out
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (req_out == '0));

  assert_disabled_no_req_R2: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (req_out == '0));

  assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> $stable(pend));

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_col
    logic [NUM_CPUS-1:0] col;
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bit
      assign col[c] = req_out[c*NUM_LINES + l];
    end
    // R7 one target, R8 all targets: never a partial subset
    assert_route_shape_R7: assert property (@(posedge clk) disable iff (rst)
      ($countones(col) <= 1) || (col == '1));

    assert_pend_clear_enabled_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(pend[l]) |-> $past(glob_en));
  end

endmodule

bind irq_route_dist irq_route_chk #(
  .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)
) chk_i (
  .clk(clk), .rst(rst), .glob_en(glob_en), .pend(pend_w), .req_out(req_out)
);

// File: tb/irq_route_dist_tb.sv
module irq_route_dist_tb_top;

  localparam int N   = 20;
  localparam int C   = 4;
  localparam int AW  = 16;
  localparam int IW  = 8;
  localparam int RW  = C * N;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_wr, reg_rd;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [N-1:0]  irq_in;
  logic [C-1:0]  ack_vld;
  logic [C*IW-1:0] ack_id;
  logic [RW-1:0] req_out;

  int total = 0;
  int bad   = 0;
  logic [1:0] mode_m [N];

  always #10 clk = ~clk;

  irq_route_dist #(.NUM_LINES(N), .NUM_CPUS(C), .ADDR_W(AW), .ID_W(IW)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .ack_vld(ack_vld), .ack_id(ack_id), .req_out(req_out)
  );

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkreq(string tag, logic [RW-1:0] exp);
    total++;
    if (req_out !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, req_out, exp);
    end
  endtask

  function automatic logic [RW-1:0] rbit(int c, int l);
    logic [RW-1:0] v = '0;
    v[c*N + l] = 1'b1;
    return v;
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ack(int c, int id);
    @(negedge clk);
    ack_vld[c] = 1'b1; ack_id[c*IW +: IW] = IW'(id);
    @(negedge clk);
    ack_vld = '0;
    wait_n(2);
  endtask

  function automatic logic [31:0] trig_word(int w);
    logic [31:0] v = '0;
    for (int l = 0; l < N; l++)
      if (l / 16 == w) v[2*(l%16) +: 2] = mode_m[l];
    return v;
  endfunction

  task automatic set_mode(int l, logic [1:0] m);
    logic [31:0] d;
    rd(32'h100 + 4*(l/16), d);
    d[2*(l%16) +: 2] = m;
    mode_m[l] = m;
    wr(32'h100 + 4*(l/16), d);
  endtask

  task automatic pulse(int l);
    @(negedge clk); irq_in[l] = 1'b1;
    wait_n(3);
    irq_in[l] = 1'b0;
    wait_n(4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    irq_in = '0; ack_vld = '0; ack_id = '0;
    for (int l = 0; l < N; l++) mode_m[l] = 2'd0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);

    // R1 reset state
    chkreq("R1 req after reset", '0);
    rd(32'h0, d);     chk32("R1 ctrl", d, 0);
    rd(32'h100, d);   chk32("R1 trig w0", d, 0);
    rd(32'h104, d);   chk32("R1 trig w1", d, 0);
    rd(32'h1000, d);  chk32("R1 tgt 0", d, 0);
    rd(32'h104C, d);  chk32("R1 tgt 19", d, 0);

    // R2 control word
    wr(32'h0, 32'hFFFF_FFFF); rd(32'h0, d); chk32("R2 ctrl set", d, 1);
    wr(32'h0, 32'hFFFF_FFFE); rd(32'h0, d); chk32("R2 ctrl clear", d, 0);

    // R3 read-modify-write of every field, then readback of all words
    for (int l = 0; l < N; l++) set_mode(l, 2'((l * 3 + 1) % 4));
    for (int w = 0; w < 3; w++) begin
      rd(32'h100 + 4*w, d);
      chk32($sformatf("R3 trig word %0d", w), d, trig_word(w));
    end
    for (int l = 0; l < N; l++) mode_m[l] = 2'd0;
    wr(32'h100, 0); wr(32'h104, 0);

    // R4 target words
    for (int l = 0; l < N; l++) begin
      logic [31:0] v = 32'(l % C) | ((l % 5 == 0) ? 32'h8000_0000 : 0);
      wr(32'h1000 + 4*l, v);
      rd(32'h1000 + 4*l, d);
      chk32($sformatf("R4 tgt line %0d", l), d, v);
    end
    wr(32'h1004, 32'hFFFF_FFFF); rd(32'h1004, d);
    chk32("R4 tgt unused bits", d, 32'h8000_0003);

    // R7/R5 sweep: every line to every processor, active-high level
    wr(32'h0, 1);
    for (int l = 0; l < N; l++) begin
      for (int c = 0; c < C; c++) begin
        wr(32'h1000 + 4*l, 32'(c));
        @(negedge clk); irq_in[l] = 1'b1;
        wait_n(5);
        chkreq($sformatf("R7 line %0d cpu %0d", l, c), rbit(c, l));
        irq_in[l] = 1'b0;
        wait_n(5);
      end
    end
    chkreq("R5 level released", '0);

    // R5 active-low level: line 3 to cpu 2
    wr(32'h100C, 2);
    set_mode(3, 2'd1);
    wait_n(5);
    chkreq("R5 low level active", rbit(2, 3));
    @(negedge clk); irq_in[3] = 1'b1;
    wait_n(5);
    chkreq("R5 low level idle", '0);
    set_mode(3, 2'd0);
    irq_in[3] = 1'b0;
    wait_n(5);

    // R9 level claim: line 0 to cpu 0
    wr(32'h1000, 0);
    @(negedge clk); irq_in[0] = 1'b1;
    wait_n(5);
    chkreq("R9 level request", rbit(0, 0));
    ack(0, 32);
    chkreq("R9 withdrawn after claim", '0);
    irq_in[0] = 1'b0; wait_n(5);
    irq_in[0] = 1'b1; wait_n(5);
    chkreq("R9 request returns", rbit(0, 0));
    irq_in[0] = 1'b0; wait_n(5);

    // R6 rising edge on line 4 to cpu 1, with rejected claims
    wr(32'h1010, 1);
    set_mode(4, 2'd2);
    pulse(4);
    chkreq("R6 rising latched", rbit(1, 4));
    ack(2, 36);
    chkreq("R7 non-target claim ignored", rbit(1, 4));
    ack(1, 37);
    chkreq("R11 wrong id ignored", rbit(1, 4));
    ack(1, 4);
    chkreq("R11 raw index ignored", rbit(1, 4));
    ack(1, 36);
    chkreq("R6 cleared by claim", '0);

    // R6 falling edge on line 6 to cpu 3
    wr(32'h1018, 3);
    set_mode(6, 2'd3);
    @(negedge clk); irq_in[6] = 1'b1;
    wait_n(5);
    chkreq("R6 falling ignores rise", '0);
    irq_in[6] = 1'b0;
    wait_n(5);
    chkreq("R6 falling latched", rbit(3, 6));
    ack(3, 38);
    chkreq("R6 falling cleared", '0);

    // R8 broadcast on line 7, rising
    wr(32'h101C, 32'h8000_0000);
    set_mode(7, 2'd2);
    pulse(7);
    chkreq("R8 offered to all", rbit(0,7) | rbit(1,7) | rbit(2,7) | rbit(3,7));
    ack(3, 39);
    chkreq("R8 first claim owns", '0);

    // R10 / R2 disable window
    pulse(4);
    chkreq("R10 pending before disable", rbit(1, 4));
    wr(32'h0, 0);
    wait_n(2);
    chkreq("R2 disabled quiet", '0);
    ack(1, 36);
    @(negedge clk); irq_in[6] = 1'b1; wait_n(5);
    irq_in[6] = 1'b0; wait_n(5);
    irq_in[0] = 1'b1; wait_n(5);
    chkreq("R2 level held off while disabled", '0);
    irq_in[0] = 1'b0; wait_n(5);
    wr(32'h0, 1);
    wait_n(3);
    chkreq("R10 pending restored, edge missed", rbit(1, 4));
    ack(1, 36);
    chkreq("R10 cleared after enable", '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule